// File: doc/BRIEF.md
# Programmable Clock Divider Channel

This block is one output channel of a clock distribution chip. It divides its input clock into an output whose high time and low time are set separately, each in whole input cycles. A chip-wide restart pulse clears the channel and holds it at a chosen start level. When the pulse ends, the channel waits a programmable number of cycles before it runs, so that several channels can be aligned with fixed offsets between them.

The channel has three other modes. It can pass the input clock straight through its divider stage (bypass). It can hold its divider output at a fixed level (static mode). It can send the raw input clock to the channel output, but only while a chip-wide permission input allows that. All settings arrive on parallel configuration inputs. Changes to the high and low counts take effect only at a full-period boundary or while the restart pulse is active, so a change never produces a short pulse. A duty-cycle-correction disable setting has no effect on the logic here. It is registered and returned on a status output.

Top module: `clkdiv_channel`

## Requirements
- R1: Each 4-bit count field holds a value v, and the matching output level lasts v+1 input cycles. `cfg_hi` sets the high level and `cfg_lo` sets the low level. With both fields at 0 the channel divides by two.
- R2: While `sync_req` is 1 and `cfg_nosync` is 0, the divider output stays at the level given by `cfg_start_hi` (1 means high, 0 means low).
- R3: Let E be the first rising edge that samples `sync_req` low after an obeyed restart. The output keeps the start level through P+F+1 edges, counting E. It first changes on edge E+P+F+1. Here P is `cfg_phase` and F is the count field of the start level (`cfg_hi` when starting high, `cfg_lo` when starting low).
- R4: When `cfg_nosync` is 1, `sync_req` has no effect and the division continues unchanged.
- R5: The high and low counts are read only during an obeyed restart, or at the edge where the output returns to the start level. A change made at any other time leaves the current half-period and the next one unchanged.
- R6: When `cfg_bypass` is 1, `div_out` equals `clk_in`. This is true whatever the static-mode settings are.
- R7: When `cfg_force` is 1, `cfg_nosync` is 1 and `cfg_bypass` is 0, `div_out` holds the value of `cfg_start_hi`. If `cfg_nosync` is 0, `cfg_force` has no effect.
- R8: `chan_out` equals `clk_in` when `cfg_direct` is 1 and `direct_block` is 0. In every other case `chan_out` equals `div_out`.
- R9: `dcc_off_q` takes the value of `cfg_dcc_off` one rising edge later.
- R10: During reset, `div_out`, `chan_out` and `dcc_off_q` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_req | input | 1 | Chip-level restart request, active high |
| cfg_hi | input | CW | High duration minus one |
| cfg_lo | input | CW | Low duration minus one |
| cfg_bypass | input | 1 | Pass clk_in through the divider stage |
| cfg_nosync | input | 1 | Ignore sync_req |
| cfg_force | input | 1 | Static output at the start level (needs cfg_nosync) |
| cfg_start_hi | input | 1 | Start level after restart |
| cfg_phase | input | CW | Cycles to wait after restart |
| cfg_direct | input | 1 | Route clk_in to chan_out |
| cfg_dcc_off | input | 1 | Duty-cycle-correction disable setting |
| direct_block | input | 1 | Chip-wide: 1 disables cfg_direct |
| div_out | output | 1 | Divider stage output |
| chan_out | output | 1 | Channel output after the direct mux |
| dcc_off_q | output | 1 | Registered cfg_dcc_off |

## Verification
The bench measures every high and low run for all 256 count pairs, with random start levels and phase offsets. A count decoded without the +1 would make each run one cycle short. It sweeps all sixteen phase offsets and checks when the first edge after a restart arrives. A design that dropped the offset, or counted it twice, would change state too early or too late. It changes the counts in the middle of a half-period and expects the old values to finish a whole period. A design that loaded the counts at once would stretch or cut a half-period. Last, it checks the order of the modes: bypass over static mode over division, static mode ignored without `cfg_nosync`, and the direct route switched off by `direct_block`. A wrong order would show a static level or the divided clock where the raw clock belongs.

// File: rtl/clkdiv_channel.sv
module clkdiv_channel #(
  parameter int CW = 4
) (
  input  logic          clk_in,
  input  logic          rst_n,
  input  logic          sync_req,
  input  logic [CW-1:0] cfg_hi,
  input  logic [CW-1:0] cfg_lo,
  input  logic          cfg_bypass,
  input  logic          cfg_nosync,
  input  logic          cfg_force,
  input  logic          cfg_start_hi,
  input  logic [CW-1:0] cfg_phase,
  input  logic          cfg_direct,
  input  logic          cfg_dcc_off,
  input  logic          direct_block,
  output logic          div_out,
  output logic          chan_out,
  output logic          dcc_off_q
);
  localparam int RW = CW + 2;

  logic          hold;
  logic          out_q, start_q;
  logic [CW-1:0] hi_q, lo_q;
  logic [RW-1:0] cnt_q;
  logic          at_end, to_start;
  logic [CW-1:0] hi_src, lo_src, first_f;
  logic          force_on;

  assign hold     = sync_req & ~cfg_nosync;
  assign at_end   = (cnt_q == '0);
  assign to_start = (out_q != start_q);
  assign hi_src   = to_start ? cfg_hi : hi_q;
  assign lo_src   = to_start ? cfg_lo : lo_q;
  assign first_f  = cfg_start_hi ? cfg_hi : cfg_lo;

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      out_q   <= 1'b0;
      start_q <= 1'b0;
      hi_q    <= '0;
      lo_q    <= '0;
      cnt_q   <= '0;
    end else if (hold) begin
      out_q   <= cfg_start_hi;
      start_q <= cfg_start_hi;
      hi_q    <= cfg_hi;
      lo_q    <= cfg_lo;
      cnt_q   <= RW'(cfg_phase) + RW'(first_f) + RW'(1);
    end else if (cfg_bypass) begin
      cnt_q <= cnt_q;
    end else if (at_end) begin
      out_q <= ~out_q;
      if (to_start) begin
        hi_q <= cfg_hi;
        lo_q <= cfg_lo;
      end
      cnt_q <= out_q ? RW'(lo_src) : RW'(hi_src);
    end else begin
      cnt_q <= cnt_q - RW'(1);
    end
  end

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) dcc_off_q <= 1'b0;
    else        dcc_off_q <= cfg_dcc_off;
  end

  assign force_on = cfg_force & cfg_nosync;
  assign div_out  = cfg_bypass ? clk_in : (force_on ? cfg_start_hi : out_q);
  assign chan_out = (cfg_direct & ~direct_block) ? clk_in : div_out;

  assert_toggle_on_zero_R1: assert property (@(posedge clk_in) disable iff (!rst_n)
    ($past(rst_n) && !$past(hold) && !$stable(out_q)) |-> ($past(cnt_q) == '0));

  assert_hold_level_R2: assert property (@(posedge clk_in) disable iff (!rst_n)
    ($past(rst_n) && $past(hold)) |-> (out_q == $past(cfg_start_hi)));

  assert_first_edge_waits_R3: assert property (@(posedge clk_in) disable iff (!rst_n)
    ($past(rst_n) && $past(hold) && !hold) |=> (out_q == $past(out_q)));

  assert_shadow_at_boundary_R5: assert property (@(posedge clk_in) disable iff (!rst_n)
    ($past(rst_n) && !$past(hold) && (!$stable(hi_q) || !$stable(lo_q)))
      |-> ($past(cnt_q) == '0 && out_q == start_q));
endmodule

// File: tb/clkdiv_channel_tb.sv
module clkdiv_channel_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_req = 1'b0;
  logic [3:0] cfg_hi = '0, cfg_lo = '0, cfg_phase = '0;
  logic cfg_bypass = 0, cfg_nosync = 0, cfg_force = 0, cfg_start_hi = 0;
  logic cfg_direct = 0, cfg_dcc_off = 0, direct_block = 0;
  logic div_out, chan_out, dcc_off_q;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  clkdiv_channel #(.CW(4)) u_dut (
    .clk_in(clk), .rst_n(rst_n), .sync_req(sync_req), .cfg_hi(cfg_hi),
    .cfg_lo(cfg_lo), .cfg_bypass(cfg_bypass), .cfg_nosync(cfg_nosync),
    .cfg_force(cfg_force), .cfg_start_hi(cfg_start_hi), .cfg_phase(cfg_phase),
    .cfg_direct(cfg_direct), .cfg_dcc_off(cfg_dcc_off), .direct_block(direct_block),
    .div_out(div_out), .chan_out(chan_out), .dcc_off_q(dcc_off_q));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit exp_lvl(int k, int p, int h, int l, bit s);
    int f, o, j;
    f = s ? h : l;
    o = s ? l : h;
    if (k <= p + f) return s;
    j = (k - (p + f + 1)) % (h + l + 2);
    return (j <= o) ? !s : s;
  endfunction

  task automatic restart(input int h, input int l, input bit s, input int p);
    @(negedge clk);
    cfg_hi = 4'(h); cfg_lo = 4'(l); cfg_start_hi = s; cfg_phase = 4'(p);
    cfg_nosync = 0; cfg_force = 0; cfg_bypass = 0;
    sync_req = 1;
    repeat (2) @(negedge clk);
    chk(div_out == s, "R2", div_out, s);
    sync_req = 0;
  endtask

  initial begin
    #800000;
    bad++; total++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk(div_out == 0 && chan_out == 0 && dcc_off_q == 0, "R10", {div_out, chan_out, dcc_off_q}, 0);
    rst_n = 1;

    for (int h = 0; h < 16; h++) begin
      for (int l = 0; l < 16; l++) begin
        bit s; int p; int errk; bit got;
        s = 1'($urandom % 2);
        p = int'($urandom % 16);
        errk = -1; got = 0;
        restart(h, l, s, p);
        for (int k = 0; k < p + 2 * (h + l + 2) + 16; k++) begin
          @(negedge clk);
          if (errk < 0 && div_out != exp_lvl(k, p, h, l, s)) begin
            errk = k; got = div_out;
          end
        end
        chk(errk < 0, "R1", got, exp_lvl(errk, p, h, l, s));
      end
    end

    for (int p = 0; p < 16; p++) begin
      int lat;
      lat = -1;
      restart(3, 6, 1'b1, p);
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (lat < 0 && div_out != 1'b1) lat = k;
      end
      chk(lat == p + 4, "R3", lat, p + 4);
    end

    begin
      int errs;
      errs = 0;
      restart(2, 2, 1'b0, 0);
      for (int k = 0; k < 20; k++) begin
        bit e;
        @(negedge clk);
        e = (k < 3) ? 0 : (k < 6) ? 1 : (k < 12) ? 0 : (k < 18) ? 1 : 0;
        if (div_out != e) errs++;
        if (k == 1) begin cfg_hi = 4'd5; cfg_lo = 4'd5; end
      end
      chk(errs == 0, "R5", errs, 0);
    end

    begin
      int errs; bit prev;
      errs = 0;
      restart(0, 0, 1'b0, 0);
      @(negedge clk);
      cfg_nosync = 1;
      prev = div_out;
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        sync_req = (k >= 3 && k < 7);
        if (div_out == prev) errs++;
        prev = div_out;
      end
      sync_req = 0;
      chk(errs == 0, "R4", errs, 0);
    end

    begin
      int errs; bit prev;
      errs = 0;
      restart(0, 0, 1'b0, 0);
      @(negedge clk);
      cfg_force = 1; cfg_start_hi = 1;
      prev = div_out;
      for (int k = 0; k < 10; k++) begin
        @(negedge clk);
        if (div_out == prev) errs++;
        prev = div_out;
      end
      chk(errs == 0, "R7 force without nosync", errs, 0);
    end

    for (int v = 0; v < 2; v++) begin
      @(negedge clk);
      cfg_nosync = 1; cfg_force = 1; cfg_bypass = 0; cfg_start_hi = 1'(v);
      repeat (3) @(negedge clk);
      chk(div_out == v, "R7 static low phase", div_out, v);
      @(posedge clk); #1;
      chk(div_out == v, "R7 static high phase", div_out, v);
    end

    @(negedge clk);
    cfg_bypass = 1; cfg_force = 1; cfg_nosync = 1; cfg_start_hi = 1;
    @(negedge clk);
    chk(div_out == 0, "R6 bypass clk low", div_out, 0);
    @(posedge clk); #1;
    chk(div_out == 1, "R6 bypass clk high", div_out, 1);
    @(negedge clk);
    cfg_start_hi = 0;
    @(posedge clk); #1;
    chk(div_out == 1, "R6 bypass over force", div_out, 1);

    @(negedge clk);
    cfg_bypass = 0; cfg_force = 1; cfg_nosync = 1; cfg_start_hi = 0;
    cfg_direct = 1; direct_block = 0;
    @(posedge clk); #1;
    chk(chan_out == 1, "R8 direct high", chan_out, 1);
    @(negedge clk);
    chk(chan_out == 0, "R8 direct low", chan_out, 0);
    direct_block = 1; cfg_start_hi = 1;
    @(posedge clk); #1;
    chk(chan_out == 1 && div_out == 1, "R8 blocked follows div", chan_out, 1);
    @(negedge clk);
    chk(chan_out == div_out && chan_out == 1, "R8 blocked low phase", chan_out, 1);
    cfg_direct = 0; direct_block = 0;
    @(negedge clk);
    chk(chan_out == 1, "R8 no direct", chan_out, 1);

    cfg_dcc_off = 1;
    @(negedge clk);
    chk(dcc_off_q == 1, "R9 set", dcc_off_q, 1);
    cfg_dcc_off = 0;
    @(negedge clk);
    chk(dcc_off_q == 0, "R9 clear", dcc_off_q, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule